// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous static memory with flow-through reads and a late-write pipeline. On every rising clock edge it registers the address, an active-low cycle select, an active-low write strobe and one active-low enable per byte lane. Read data appears in the cycle that follows the edge that captured the read address. Write data trails its address by one clock. A captured write is not placed in the array at once. Its address, lane mask and data wait in holding registers, and they go into the array only at the next write cycle that is not aborted. Any read cycles in between leave them waiting.

Every read address is compared with the waiting write address. On a match, each lane that the waiting write enables is taken from the holding register, and every other lane is taken from the array. The read data bus is enabled only for read cycles while the asynchronous output enable is low and the asynchronous sleep input is low. Sleep also discards the waiting write. After sleep is released, the block refuses operations for a fixed number of clock edges.

Top module: `latewr_sram`

## Requirements
- R1: A cycle with `sel_n`=0 and `wen_n`=1 is a read. After the edge that captures it, `dout_en` is 1 and `dout` carries all `LANES*LANE_W` bits stored at that address, within the same cycle (flow-through).
- R2: For a write, `din` is sampled at the rising edge that follows the edge where the address and controls were captured.
- R3: A write stays pending through any number of read, deselect or abort cycles. It is committed to the array at the next non-aborted write. After that commit, a read of its address returns the merged word from the array.
- R4: A read whose address equals the pending write address returns lane l (bits [LANE_W*l+LANE_W-1 : LANE_W*l]) from the pending data when `ben_n[l]` was 0 for that write, and from the array otherwise.
- R5: A write cycle with every `ben_n` bit at 1 is an abort. It keeps `dout_en` at 0, samples no data, changes no array word, and leaves an earlier pending write pending.
- R6: A cycle with `sel_n`=1 is a deselect. It keeps `dout_en` at 0 and changes no stored data.
- R7: `oe_n`=1 or `sleep`=1 forces `dout_en` to 0 with no clock edge needed. Returning `oe_n` to 0 during a read cycle restores the output without an edge. `dout` reads 0 whenever `dout_en` is 0.
- R8: A rising edge with `sleep`=1 discards the pending write and its data. The array keeps its earlier contents.
- R9: The first `WAKE_CYC` (4) rising edges after `sleep` falls are blocked. Reads give `dout_en`=0, and writes are ignored. The next edge accepts a normal cycle.
- R10: After synchronous reset, `dout_en` is 0 and no write is pending.
- R11: Back-to-back writes are supported. The second write's edge samples the first write's data and commits it in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, registered at the edge |
| sel_n | input | 1 | Active-low cycle select; 1 means deselect |
| wen_n | input | 1 | Active-low write strobe; 1 means read |
| ben_n | input | LANES | Active-low per-lane write enables |
| din | input | LANES*LANE_W | Write data, sampled one edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dout | output | LANES*LANE_W | Read data; 0 when not driven |
| dout_en | output | 1 | Tri-state drive enable for the data bus |

## Verification
The bench builds the block with `ADDR_W`=4, four lanes of 9 bits and `WAKE_CYC`=4. The whole 16-word space can therefore be filled and every address visited. Each address is then written once with every one of the 15 non-empty lane masks. After each such write, the bench reads the word while the write is pending, reads it again after an unrelated read, and reads it a third time after a later write has committed it. The expected values come from a reference memory that applies writes immediately, plus arithmetic data patterns. The small space also lets the bench target the abort, sleep-discard and blocked-recovery windows at chosen addresses whose old contents it already knows.

// File: rtl/latewr_pkg.sv
package latewr_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/latewr_ctrl.sv
module latewr_ctrl
  import latewr_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             wen_n,
  input  logic [LANES-1:0] ben_n,
  input  logic             sleep,
  output cyc_e             cyc
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic [CNT_W-1:0] wake_q;
  logic             blocked;

  // recovery window: loaded while asleep, counts down after release
  always_ff @(posedge clk) begin
    if (rst)                 wake_q <= '0;
    else if (sleep)          wake_q <= CNT_W'(WAKE_CYC);
    else if (wake_q != '0)   wake_q <= wake_q - 1'b1;
  end

  assign blocked = sleep | (wake_q != '0);

  always_comb begin
    if (rst || blocked || sel_n) cyc = CYC_IDLE;
    else if (wen_n)              cyc = CYC_READ;
    else if (&ben_n)             cyc = CYC_IDLE;   // abort write
    else                         cyc = CYC_WRITE;
  end

  p_wake_bounded_r9: assert property (@(posedge clk) disable iff (rst)
    wake_q <= CNT_W'(WAKE_CYC));

  p_wake_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sleep) && $past(wake_q) != '0)
      |-> wake_q == $past(wake_q) - 1'b1);
endmodule

// File: rtl/latewr_wbuf.sv
module latewr_wbuf
  import latewr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  cyc_e                    cyc,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        ben_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES*LANE_W-1:0] arr_q,
  output logic                    cm_we,
  output logic [ADDR_W-1:0]       cm_addr,
  output logic [LANES-1:0]        cm_mask,
  output logic [LANES*LANE_W-1:0] cm_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DW = LANES * LANE_W;

  logic [ADDR_W-1:0] hold_addr;
  logic [LANES-1:0]  hold_mask;
  logic [DW-1:0]     hold_data;
  logic              hold_valid;
  logic              due_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      hold_valid <= 1'b0;
      due_q      <= 1'b0;
    end else begin
      due_q <= (cyc == CYC_WRITE);
      if (cyc == CYC_WRITE) hold_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !sleep && due_q) hold_data <= din;
    if (cyc == CYC_WRITE) begin
      hold_addr <= addr;
      hold_mask <= ~ben_n;
    end
    if (cyc == CYC_READ) rd_addr_q <= addr;
  end

  // commit the waiting write when the next real write arrives
  assign cm_we   = (cyc == CYC_WRITE) && hold_valid;
  assign cm_addr = hold_addr;
  assign cm_mask = hold_mask;
  assign cm_data = due_q ? din : hold_data;

  assign hit = hold_valid && (rd_addr_q == hold_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign rd_data[l*LANE_W +: LANE_W] = (hit && hold_mask[l])
                                         ? hold_data[l*LANE_W +: LANE_W]
                                         : arr_q[l*LANE_W +: LANE_W];
  end

  p_due_needs_hold_r2: assert property (@(posedge clk) disable iff (rst)
    due_q |-> hold_valid);

  p_commit_mask_r5: assert property (@(posedge clk) disable iff (rst)
    cm_we |-> hold_mask != '0);

  p_sleep_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(sleep) |-> !hold_valid && !due_q);
endmodule

// File: rtl/latewr_array.sv
module latewr_array #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  // one simple-dual-port memory per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we && wmask[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      if (re)             q <= mem[raddr];
    end

    assign rd_q[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/latewr_sram.sv
module latewr_sram
  import latewr_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_n,
  input  logic                    wen_n,
  input  logic [LANES-1:0]        ben_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DW = LANES * LANE_W;

  cyc_e              cyc;
  logic              cm_we;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_mask;
  logic [DW-1:0]     cm_data;
  logic [DW-1:0]     arr_q;
  logic [DW-1:0]     rd_data;
  logic              rd_live_q;

  latewr_ctrl #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) ctrl_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wen_n(wen_n),
    .ben_n(ben_n), .sleep(sleep), .cyc(cyc)
  );

  latewr_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) wbuf_i (
    .clk(clk), .rst(rst), .sleep(sleep), .cyc(cyc), .addr(addr),
    .ben_n(ben_n), .din(din), .arr_q(arr_q), .cm_we(cm_we),
    .cm_addr(cm_addr), .cm_mask(cm_mask), .cm_data(cm_data),
    .rd_data(rd_data)
  );

  latewr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wmask(cm_mask),
    .wdata(cm_data), .re(cyc == CYC_READ), .raddr(addr), .rd_q(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_live_q <= 1'b0;
    else     rd_live_q <= (cyc == CYC_READ);
  end

  // asynchronous gating by output enable and sleep
  assign dout_en = rd_live_q && !oe_n && !sleep;
  assign dout    = dout_en ? rd_data : '0;

  p_drive_src_r1: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(!sel_n && wen_n && !sleep));

  p_desel_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(sel_n) |-> !rd_live_q);

  p_abort_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!wen_n) |-> !rd_live_q);

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> !rd_live_q);
endmodule

// File: tb/latewr_sram_tb_top.sv
`timescale 1ns/1ps
module latewr_sram_tb_top;
  localparam int AW = 4;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          sel_n, wen_n, oe_n, sleep;
  logic [LN-1:0] ben_n;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  always #2.5 clk = ~clk;

  latewr_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .WAKE_CYC(4)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .wen_n(wen_n),
    .ben_n(ben_n), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] refm [NW];
  logic [DW-1:0] din_next = '0;

  function automatic logic [DW-1:0] pat(int a, int k);
    logic [63:0] v;
    v = 64'(a) * 64'h1020_4081 + 64'(k) * 64'h9E37_79B9 + 64'h5_A5A5_A5A5;
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] lanes(logic [LN-1:0] m);
    logic [DW-1:0] r = '0;
    for (int l = 0; l < LN; l++) if (m[l]) r[l*LW +: LW] = '1;
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(int a, logic [LN-1:0] m, logic [DW-1:0] d);
    sel_n = 1'b0; wen_n = 1'b0; ben_n = ~m; addr = AW'(a); din = din_next;
    tick();
    din_next = d;
    refm[a] = (refm[a] & ~lanes(m)) | (d & lanes(m));
  endtask

  task automatic do_read(int a, string req);
    sel_n = 1'b0; wen_n = 1'b1; ben_n = '1; addr = AW'(a); din = din_next;
    tick();
    chk(req, DW'(dout_en), DW'(1));
    chk(req, dout, refm[a]);
  endtask

  task automatic do_quiet(logic s, logic w, int a, string req);
    sel_n = s; wen_n = w; ben_n = '1; addr = AW'(a); din = din_next;
    tick();
    chk(req, DW'(dout_en), DW'(0));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] old5, old9;
    rst = 1'b1; sel_n = 1'b1; wen_n = 1'b1; ben_n = '1; addr = '0;
    din = '0; oe_n = 1'b0; sleep = 1'b0;
    for (int i = 0; i < NW; i++) refm[i] = '0;
    repeat (3) tick();
    rst = 1'b0;
    chk("R10 reset quiet", DW'(dout_en), DW'(0));
    tick();
    chk("R10 idle after reset", DW'(dout_en), DW'(0));

    // R11/R2: back-to-back full writes fill the space, then R1 reads
    for (int a = 0; a < NW; a++) do_write(a, 4'hF, pat(a, 0));
    for (int a = 0; a < NW; a++) do_read(a, "R1 fill readback");

    // R4/R3: every non-empty lane mask at every address
    for (int a = 0; a < NW; a++) begin
      for (int m = 1; m < 16; m++) begin
        do_write(a, LN'(m), pat(a, m));
        do_read(a, "R4 forward pending lanes");
        do_read(a ^ 1, "R1 unrelated read");
        do_read(a, "R3 still pending after read");
        do_write(a ^ 5, 4'hF, pat(a ^ 5, m + 20));
        do_read(a, "R3 committed merge");
      end
    end

    // R5: abort leaves the earlier write pending and drives nothing
    do_write(2, 4'hF, pat(2, 77));
    do_quiet(1'b0, 1'b0, 2, "R5 abort no drive");
    din = ~din_next;
    do_read(2, "R5 pending survives abort");
    do_write(7, 4'hF, pat(7, 78));
    do_read(2, "R5 abort wrote nothing");

    // R6: deselect
    do_quiet(1'b1, 1'b0, 7, "R6 deselect no drive");
    do_read(7, "R6 data unchanged");

    // R7: asynchronous output enable and sleep gating
    oe_n = 1'b1;
    do_quiet(1'b0, 1'b1, 3, "R7 oe_n high");
    oe_n = 1'b0; #1;
    chk("R7 oe_n async on", DW'(dout_en), DW'(1));
    chk("R7 oe_n async data", dout, refm[3]);
    sleep = 1'b1; #1;
    chk("R7 sleep async off", DW'(dout_en), DW'(0));
    chk("R7 dout zero when off", dout, '0);
    sleep = 1'b0; #1;

    // R8/R9: sleep discards the pending write; four blocked edges
    old5 = refm[5];
    old9 = refm[9];
    do_write(5, 4'hF, pat(5, 99));
    sleep = 1'b1; din = din_next;
    tick(); tick();
    sleep = 1'b0;
    refm[5] = old5;
    do_quiet(1'b0, 1'b1, 5, "R9 blocked read 1");
    do_quiet(1'b0, 1'b1, 5, "R9 blocked read 2");
    do_quiet(1'b0, 1'b1, 5, "R9 blocked read 3");
    sel_n = 1'b0; wen_n = 1'b0; ben_n = '0; addr = AW'(9); din = pat(9, 55);
    tick();
    chk("R9 blocked write no drive", DW'(dout_en), DW'(0));
    din = pat(9, 56);
    do_read(5, "R8 pending write discarded");
    do_read(9, "R9 blocked write ignored");
    chk("R9 old word kept", refm[9], old9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule